// File: doc/BRIEF.md
# Domain-Phased Switch Allocator

This block decides, once per cycle, which virtual channels of a router move a flit through the crossbar. The router time-multiplexes its allocation stages between traffic domains. Each input port holds one group of virtual channels per domain, and only the group belonging to the domain that currently owns the switch-allocation phase may take part. The phase is supplied from outside as a domain number. Packets of different domains therefore never contend for an arbiter, a crossbar output or a priority pointer in the same cycle.

Allocation is separable and has two steps. In the first step, every input port picks one of its eligible channels of the active domain in round-robin order. A channel is eligible when it has a flit ready with an output channel already assigned and the downstream buffer has room. In the second step, every output port picks one of the input ports whose local winner targets it, again in round-robin order. Each arbiter keeps a separate priority pointer for every domain, and the phase chooses which pointer is read and updated. One cycle after each grant, a pulse marks the granted channel so that the credit count of its downstream buffer can be decremented.

Top module: `dom_sw_alloc`

## Requirements
- R1: A channel is granted only if both its request bit and its credit-available bit are 1 in the same cycle.
- R2: Each input port has at most one of its channels granted per cycle. A channel that wins locally but loses at the output receives no grant.
- R3: Each output's crossbar select (bit `o*NPORT+i` selects input `i` for output `o`) has at most one bit set. Each input is selected by at most one output. A selected input's granted channel names that output in its port field.
- R4: At an input, the local choice is the first eligible channel in ascending index order (wrapping) after the channel that last won all the way through at that input in the active domain. After reset the search starts at channel 0.
- R5: At an output, the choice is the first requesting input in ascending order (wrapping) after the input last granted by that output in the active domain. After reset the search starts at input 0.
- R6: Grants made while one domain holds the phase leave every other domain's priority pointers unchanged.
- R7: An input's local pointer moves only when that input also wins its output. A local winner that loses is offered again first the next time its domain holds the phase.
- R8: `cred_use_o` equals the channel grants of the previous cycle as a one-cycle pulse. `cred_dom_o` then carries that previous cycle's phase.
- R9: Every output that has at least one requesting local winner grants one of them.
- R10: During reset and in the first cycle after it, `cred_use_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa_dom_i | input | DW | Domain that owns the allocation phase this cycle |
| vc_req_i | input | NPORT*VPD | Per input channel of the active domain: flit ready with an output channel assigned (bit `i*VPD+v`) |
| vc_port_i | input | NPORT*VPD*PW | Target output port of each channel, PW bits per channel, in the same order |
| vc_cred_i | input | NPORT*VPD | Downstream buffer of the channel's assigned output channel has room |
| vc_gnt_o | output | NPORT*VPD | Channel grants this cycle |
| xbar_sel_o | output | NPORT*NPORT | One-hot input select per output port |
| cred_use_o | output | NPORT*VPD | Credit-consume pulse, one cycle after the grant |
| cred_dom_o | output | DW | Domain that the pulsing channels belong to |

## Verification
On every cycle, the assertions check the structural guarantees: grants go only to eligible channels, there is at most one grant per input and per output, and every crossbar select agrees with the port field of the granted channel. Fairness order, domain separation of the pointers, the rule that a losing local winner keeps its priority, and the timing of the credit pulse all depend on history. Only the bench's reference model shows these, through directed scenarios that hammer one output, switch domains midway and withhold credits, and through a long randomized phase-cycling run.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // width of an index over n items, never below one bit
  function automatic int wbits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
  parameter int N    = 4,
  parameter int NSET = 4,
  parameter int SW   = sa_pkg::wbits(NSET)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_i,
  input  logic [N-1:0]  req_i,
  input  logic          upd_i,
  output logic [N-1:0]  gnt_o
);
  localparam int IW = sa_pkg::wbits(N);

  logic [IW-1:0] last_q [NSET];
  logic [IW-1:0] cur;
  logic [IW-1:0] win_idx;
  logic          wr_en;

  // next-state: pick first requester after the stored pointer of this set
  always_comb begin
    int  idx;
    logic found;
    cur = IW'(N-1);
    for (int s = 0; s < NSET; s++)
      if (set_i == SW'(s)) cur = last_q[s];
    gnt_o = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(cur) + k) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i]) win_idx = IW'(i);
    wr_en = upd_i && found;
  end

  // one pointer register per set, enabled only for the active set
  for (genvar s = 0; s < NSET; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        last_q[s] <= IW'(N-1);
      else if (wr_en && (set_i == SW'(s)))
        last_q[s] <= win_idx;
    end
  end

  p_arb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  p_arb_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/sa_in_port.sv
module sa_in_port #(
  parameter int VPD  = 2,
  parameter int NDOM = 4,
  parameter int PW   = 3,
  parameter int DW   = sa_pkg::wbits(NDOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     dom_i,
  input  logic [VPD-1:0]    req_i,
  input  logic [VPD-1:0]    cred_i,
  input  logic [VPD*PW-1:0] port_i,
  input  logic              won_i,
  output logic [VPD-1:0]    lgnt_o,
  output logic              any_o,
  output logic [PW-1:0]     tgt_o
);
  logic [VPD-1:0] elig;

  assign elig = req_i & cred_i;

  sa_rr_arb #(.N(VPD), .NSET(NDOM), .SW(DW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (dom_i),
    .req_i (elig),
    .upd_i (won_i),
    .gnt_o (lgnt_o)
  );

  always_comb begin
    any_o = |lgnt_o;
    tgt_o = '0;
    for (int v = 0; v < VPD; v++)
      if (lgnt_o[v]) tgt_o = port_i[v*PW +: PW];
  end

  p_local_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lgnt_o & ~(req_i & cred_i)) == '0);
endmodule

// File: rtl/dom_sw_alloc.sv
module dom_sw_alloc #(
  parameter int NPORT = 5,
  parameter int NDOM  = 4,
  parameter int VPD   = 2,
  parameter int DW    = sa_pkg::wbits(NDOM),
  parameter int PW    = sa_pkg::wbits(NPORT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           sa_dom_i,
  input  logic [NPORT*VPD-1:0]    vc_req_i,
  input  logic [NPORT*VPD*PW-1:0] vc_port_i,
  input  logic [NPORT*VPD-1:0]    vc_cred_i,
  output logic [NPORT*VPD-1:0]    vc_gnt_o,
  output logic [NPORT*NPORT-1:0]  xbar_sel_o,
  output logic [NPORT*VPD-1:0]    cred_use_o,
  output logic [DW-1:0]           cred_dom_o
);
  localparam int NVC = NPORT * VPD;

  logic [VPD-1:0]   s1_gnt [NPORT];
  logic [NPORT-1:0] s1_any;
  logic [PW-1:0]    s1_tgt [NPORT];
  logic [NPORT-1:0] s2_req [NPORT];
  logic [NPORT-1:0] s2_gnt [NPORT];
  logic [NPORT-1:0] won;
  logic [NVC-1:0]   cred_q, cred_d;
  logic [DW-1:0]    dom_q, dom_d;
  logic             dom_en;

  // stage one: local choice per input port
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    sa_in_port #(.VPD(VPD), .NDOM(NDOM), .PW(PW), .DW(DW)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .dom_i  (sa_dom_i),
      .req_i  (vc_req_i[i*VPD +: VPD]),
      .cred_i (vc_cred_i[i*VPD +: VPD]),
      .port_i (vc_port_i[i*VPD*PW +: VPD*PW]),
      .won_i  (won[i]),
      .lgnt_o (s1_gnt[i]),
      .any_o  (s1_any[i]),
      .tgt_o  (s1_tgt[i])
    );
  end

  // stage two request matrix
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        s2_req[o][i] = s1_any[i] && (s1_tgt[i] == PW'(o));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    sa_rr_arb #(.N(NPORT), .NSET(NDOM), .SW(DW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sa_dom_i),
      .req_i (s2_req[o]),
      .upd_i (1'b1),
      .gnt_o (s2_gnt[o])
    );
    assign xbar_sel_o[o*NPORT +: NPORT] = s2_gnt[o];
  end

  always_comb begin
    won = '0;
    for (int o = 0; o < NPORT; o++)
      won = won | s2_gnt[o];
    for (int i = 0; i < NPORT; i++)
      vc_gnt_o[i*VPD +: VPD] = won[i] ? s1_gnt[i] : '0;
  end

  // credit-consume pulse, next-state then register
  always_comb begin
    cred_d = vc_gnt_o;
    dom_en = |vc_gnt_o;
    dom_d  = sa_dom_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
      dom_q  <= '0;
    end else begin
      cred_q <= cred_d;
      if (dom_en) dom_q <= dom_d;
    end
  end

  assign cred_use_o = cred_q;
  assign cred_dom_o = dom_q;

  // checks at the block boundary
  p_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_gnt_o & ~(vc_req_i & vc_cred_i)) == '0);

  for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
    p_xbar_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel_o[o*NPORT +: NPORT]));
    for (genvar i = 0; i < NPORT; i++) begin : g_chk_in
      logic [VPD-1:0] hit;
      always_comb
        for (int v = 0; v < VPD; v++)
          hit[v] = vc_gnt_o[i*VPD+v] && (vc_port_i[(i*VPD+v)*PW +: PW] == PW'(o));
      p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xbar_sel_o[o*NPORT+i] |-> (|hit));
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk_vc
    logic [NPORT-1:0] col;
    always_comb
      for (int o = 0; o < NPORT; o++) col[o] = xbar_sel_o[o*NPORT+i];
    p_in_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    p_vc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vc_gnt_o[i*VPD +: VPD]) && ((|vc_gnt_o[i*VPD +: VPD]) == (|col)));
  end

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|vc_gnt_o) |=> ($countones(cred_use_o) > 0) && (cred_dom_o == $past(sa_dom_i)));
endmodule

// File: tb/sim_dom_sw_alloc.sv
module sim_dom_sw_alloc;
  localparam int NP = 5, ND = 4, NV = 2, DW = 2, PW = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [DW-1:0]        dom;
  logic [NP*NV-1:0]     req, cred;
  logic [NP*NV*PW-1:0]  port;
  logic [NP*NV-1:0]     gnt, cuse;
  logic [NP*NP-1:0]     xsel;
  logic [DW-1:0]        cdom;

  int n_chk = 0, n_fail = 0;
  int p1 [ND][NP];
  int p2 [ND][NP];
  logic [NP*NV-1:0] e_gnt, prev_gnt;
  logic [NP*NP-1:0] e_xsel;
  logic [DW-1:0]    prev_dom;

  always #5 clk = ~clk;

  dom_sw_alloc #(.NPORT(NP), .NDOM(ND), .VPD(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .sa_dom_i(dom), .vc_req_i(req), .vc_port_i(port),
    .vc_cred_i(cred), .vc_gnt_o(gnt), .xbar_sel_o(xsel), .cred_use_o(cuse),
    .cred_dom_o(cdom));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < NP; k++) begin
        p1[d][k] = NV - 1;
        p2[d][k] = NP - 1;
      end
    prev_gnt = '0;
    prev_dom = '0;
  endtask

  // behavioural expectation for the current inputs
  task automatic model_eval();
    int lw [NP];
    int tg [NP];
    int d, w;
    d = int'(dom);
    e_gnt = '0;
    e_xsel = '0;
    for (int i = 0; i < NP; i++) begin
      lw[i] = -1;
      for (int k = 1; k <= NV; k++) begin
        w = (p1[d][i] + k) % NV;
        if (lw[i] < 0 && req[i*NV+w] && cred[i*NV+w]) lw[i] = w;
      end
      tg[i] = (lw[i] >= 0) ? int'(port[(i*NV+lw[i])*PW +: PW]) : -1;
    end
    for (int o = 0; o < NP; o++) begin
      w = -1;
      for (int k = 1; k <= NP; k++) begin
        int c;
        c = (p2[d][o] + k) % NP;
        if (w < 0 && tg[c] == o) w = c;
      end
      if (w >= 0) begin
        e_xsel[o*NP+w] = 1'b1;
        e_gnt[w*NV+lw[w]] = 1'b1;
        p2[d][o] = w;
        p1[d][w] = lw[w];
      end
    end
  endtask

  // drive at negedge, compare 1ns later, then advance the model
  task automatic step(input int d, input logic [NP*NV-1:0] r,
                      input logic [NP*NV-1:0] c, input logic [NP*NV*PW-1:0] p);
    @(negedge clk);
    dom = DW'(d); req = r; cred = c; port = p;
    #1;
    chk("R8 cred_use_o", 64'(cuse), 64'(prev_gnt));
    if (|prev_gnt) chk("R8 cred_dom_o", 64'(cdom), 64'(prev_dom));
    model_eval();
    chk("R1 R2 R4 R6 R7 vc_gnt_o", 64'(gnt), 64'(e_gnt));
    chk("R3 R5 R9 xbar_sel_o", 64'(xsel), 64'(e_xsel));
    prev_gnt = e_gnt;
    prev_dom = dom;
  endtask

  function automatic logic [NP*NV*PW-1:0] all_to(input int o);
    logic [NP*NV*PW-1:0] p;
    for (int k = 0; k < NP*NV; k++) p[k*PW +: PW] = PW'(o);
    return p;
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dom = '0; req = '0; cred = '0; port = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R10 cred_use_o in reset", 64'(cuse), 64'd0);
    chk("R10 vc_gnt_o in reset idle", 64'(gnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 cred_use_o after reset", 64'(cuse), 64'd0);

    // R7: inputs 0 and 1, both channels, all to output 0
    step(0, 10'b00_0000_1111, '1, all_to(0));
    chk("R7 first grant input0 ch0", 64'(gnt), 64'h001);
    step(0, 10'b00_0000_1111, '1, all_to(0));
    chk("R7 loser keeps ch0", 64'(gnt), 64'h004);
    // R6: domain 1 untouched by domain 0 history
    step(1, 10'b00_0000_0011, '1, all_to(2));
    chk("R6 domain1 starts at ch0", 64'(gnt), 64'h001);
    // R1: credits withheld
    step(0, '1, '0, all_to(1));
    chk("R1 no credit no grant", 64'(gnt), 64'h000);
    step(0, '1, 10'b0101010101, all_to(1));
    chk("R1 only credited channels", 64'(gnt & ~10'b0101010101), 64'h000);
    // R5: hammer output 3 from all inputs
    for (int n = 0; n < 12; n++) step(2, '1, '1, all_to(3));
    // domain switching mid-stream
    for (int n = 0; n < 8; n++) step(n % ND, '1, '1, all_to(n % NP));
    // randomized, phase cycling
    for (int n = 0; n < 600; n++) begin
      logic [NP*NV*PW-1:0] p;
      for (int k = 0; k < NP*NV; k++) p[k*PW +: PW] = PW'($urandom_range(0, NP-1));
      step(n % ND, NP*NV'($urandom), NP*NV'($urandom | $urandom), p);
    end
    step(0, '0, '0, '0);
    step(0, '0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule